// File: doc/BRIEF.md
# PWM Input Capture Unit

This block measures an external pulse-width-modulated signal with a single up-counting timebase and two capture registers. Both registers watch the same input pin, each on the opposite edge. A selectable trigger edge clears the counter and records the full period. The other edge records how long the active level lasted. Software reads the two values and works out frequency and duty ratio from them.

The input is asynchronous. It passes through a two-flop synchronizer and a programmable stability filter before edges are detected. A timebase prescaler sets the tick rate. A capture prescaler thins out the recorded edges. Each period capture raises a sticky interrupt flag. If no trigger edge arrives before the counter runs past its top value, the unit sets an overflow flag and reports a period of zero.

Top module: `pwm_capture_unit`

## Requirements
- R1: After reset, period_o, width_o, irq_o and ovf_o are all zero.
- R2: With trig_pol_i=0, rising edges are trigger edges. After a few steady cycles, period_o equals the spacing between rising edges in ticks. With tb_psc_i=0 one tick is one clock.
- R3: With trig_pol_i=0, width_o equals the high time in ticks: the count from a rising edge to the next falling edge.
- R4: With trig_pol_i=1, falling edges are trigger edges. period_o still equals the full period, and width_o equals the low time in ticks.
- R5: A timebase setting of P makes one tick every P+1 clocks. A span of M*(P+1) clocks then reads as M.
- R6: Capture prescaler code c (0..3) records only every 2^c-th qualifying edge on each channel, counting from reset. Edges before that leave irq_o and the capture values unchanged.
- R7: Filter code N accepts a level only after N+1 consecutive equal synchronized samples. Code 0 accepts every sample. A pulse shorter than N+1 clocks causes no capture.
- R8: irq_o is set by each period capture. It stays set until a one-cycle clr_i pulse clears it.
- R9: If the counter wraps past 0xFFFF with no trigger edge, ovf_o is set and period_o reads zero.
- R10: clr_i also clears ovf_o. The first trigger after a wrap stores a period of zero. The trigger after that stores a valid period again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwm_i | input | 1 | Asynchronous PWM input |
| tb_psc_i | input | 16 | Timebase divider; tick every value+1 clocks |
| trig_pol_i | input | 1 | 0: rising edge triggers, 1: falling edge triggers |
| cap_psc_i | input | 2 | Capture every 1, 2, 4 or 8 edges |
| filt_i | input | 4 | Filter length code |
| clr_i | input | 1 | Clears irq_o and ovf_o |
| period_o | output | 16 | Last captured period in ticks |
| width_o | output | 16 | Last captured active-level width in ticks |
| irq_o | output | 1 | Sticky period-capture flag |
| ovf_o | output | 1 | Sticky counter-wrap flag |

## Verification
Two asymmetric waveforms are run with the rising-edge trigger. Because their high and low times differ, a swap of the two capture registers shows up at once. The same waveform with the falling-edge trigger must give an unchanged period but the low time instead of the high time. Runs at timebase settings 3 and 5 with spans that are exact multiples tell a divide by P+1 apart from a divide by P. A short glitch under a long filter, single edges under a capture divide of two, and a long idle spell that forces a wrap cover the thinning, the filter and the zero-period paths.

// File: rtl/pwmcap_pkg.sv
package pwmcap_pkg;
  typedef struct packed {
    logic opp;   // edge opposite to the trigger
    logic trig;  // trigger edge
  } edge_evt_t;
endpackage

// File: rtl/pwmcap_in_cond.sv
module pwmcap_in_cond
  import pwmcap_pkg::*;
#(
  parameter int FILT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwm_i,
  input  logic [FILT_W-1:0] filt_i,
  input  logic              trig_pol_i,
  output edge_evt_t         evt_o
);
  localparam int RUN_W = FILT_W + 1;

  logic              s1_q, s2_q, s3_q, f_q, fd_q;
  logic [FILT_W-1:0] run_q;
  logic [RUN_W-1:0]  stable_n;
  logic              accept, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pwm_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  // extra samples equal to the current one
  always_comb begin
    stable_n = (s2_q == s3_q) ? ({1'b0, run_q} + RUN_W'(1)) : '0;
    accept   = stable_n >= {1'b0, filt_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      f_q   <= 1'b0;
      fd_q  <= 1'b0;
    end else begin
      run_q <= stable_n[FILT_W] ? '1 : stable_n[FILT_W-1:0];
      if (accept) f_q <= s2_q;
      fd_q <= f_q;
    end
  end

  assign rise = f_q & ~fd_q;
  assign fall = ~f_q & fd_q;

  always_comb begin
    evt_o.trig = trig_pol_i ? fall : rise;
    evt_o.opp  = trig_pol_i ? rise : fall;
  end

  // R7
  filt_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(f_q) |-> f_q == $past(s2_q));
endmodule

// File: rtl/pwmcap_timebase.sv
module pwmcap_timebase #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [PSC_W-1:0] pc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign tick   = ~trig_i & (pc_q >= psc_i);
  assign wrap_o = tick & (&cnt_q);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      cnt_q <= '0;
    end else if (trig_i) begin
      pc_q  <= '0;
      cnt_q <= '0;
    end else begin
      pc_q <= tick ? '0 : pc_q + PSC_W'(1);
      if (tick) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R2
  trig_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> cnt_q == '0);
  // R5
  psc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_i && pc_q < psc_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pwmcap_capture.sv
module pwmcap_capture
  import pwmcap_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int CPSC_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  edge_evt_t         evt_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              wrap_i,
  input  logic [CPSC_W-1:0] cap_psc_i,
  input  logic              clr_i,
  output logic [CNT_W-1:0]  period_o,
  output logic [CNT_W-1:0]  width_o,
  output logic              irq_o,
  output logic              ovf_o
);
  localparam int PC_W = (2 ** CPSC_W) - 1;

  logic [1:0]       ev_vec, take;
  logic [PC_W-1:0]  lim;
  logic [CNT_W-1:0] period_q, width_q, meas;
  logic             irq_q, ovf_q, lost_q;

  assign ev_vec = {evt_i.opp, evt_i.trig};
  assign lim    = (PC_W'(1) << cap_psc_i) - PC_W'(1);
  assign meas   = lost_q ? '0 : cnt_i + CNT_W'(1);

  for (genvar ch = 0; ch < 2; ch++) begin : g_div
    logic [PC_W-1:0] ecnt_q;
    assign take[ch] = ev_vec[ch] & (ecnt_q >= lim);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         ecnt_q <= '0;
      else if (take[ch])   ecnt_q <= '0;
      else if (ev_vec[ch]) ecnt_q <= ecnt_q + PC_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      width_q  <= '0;
      irq_q    <= 1'b0;
      ovf_q    <= 1'b0;
      lost_q   <= 1'b0;
    end else begin
      if (wrap_i)       period_q <= '0;
      else if (take[0]) period_q <= meas;
      if (take[1])      width_q  <= meas;
      if (wrap_i)          lost_q <= 1'b1;
      else if (ev_vec[0])  lost_q <= 1'b0;
      if (take[0])     irq_q <= 1'b1;
      else if (clr_i)  irq_q <= 1'b0;
      if (wrap_i)      ovf_q <= 1'b1;
      else if (clr_i)  ovf_q <= 1'b0;
    end
  end

  assign period_o = period_q;
  assign width_o  = width_q;
  assign irq_o    = irq_q;
  assign ovf_o    = ovf_q;

  // R8
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !clr_i) |=> irq_q);
  // R6
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(ev_vec[0]));
  // R9
  ovf_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> (ovf_q && period_q == '0));
  // R10
  ovf_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !wrap_i) |=> !ovf_q);
endmodule

// File: rtl/pwm_capture_unit.sv
module pwm_capture_unit
  import pwmcap_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int FILT_W = 4,
  parameter int CPSC_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwm_i,
  input  logic [PSC_W-1:0]  tb_psc_i,
  input  logic              trig_pol_i,
  input  logic [CPSC_W-1:0] cap_psc_i,
  input  logic [FILT_W-1:0] filt_i,
  input  logic              clr_i,
  output logic [CNT_W-1:0]  period_o,
  output logic [CNT_W-1:0]  width_o,
  output logic              irq_o,
  output logic              ovf_o
);
  edge_evt_t        evt;
  logic [CNT_W-1:0] cnt;
  logic             wrap;

  pwmcap_in_cond #(.FILT_W(FILT_W)) u_in (
    .clk_i, .rst_ni, .pwm_i, .filt_i, .trig_pol_i, .evt_o(evt)
  );

  pwmcap_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tb (
    .clk_i, .rst_ni, .trig_i(evt.trig), .psc_i(tb_psc_i),
    .cnt_o(cnt), .wrap_o(wrap)
  );

  pwmcap_capture #(.CNT_W(CNT_W), .CPSC_W(CPSC_W)) u_cap (
    .clk_i, .rst_ni, .evt_i(evt), .cnt_i(cnt), .wrap_i(wrap),
    .cap_psc_i, .clr_i, .period_o, .width_o, .irq_o, .ovf_o
  );
endmodule

// File: tb/pwm_capture_unit_tb_top.sv
`timescale 1ns/1ps
module pwm_capture_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwm = 1'b0;
  logic [15:0] tb_psc = '0;
  logic        pol = 1'b0;
  logic [1:0]  cpsc = '0;
  logic [3:0]  filt = '0;
  logic        clr = 1'b0;
  logic [15:0] period, width;
  logic        irq, ovf;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  pwm_capture_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwm_i(pwm), .tb_psc_i(tb_psc),
    .trig_pol_i(pol), .cap_psc_i(cpsc), .filt_i(filt), .clr_i(clr),
    .period_o(period), .width_o(width), .irq_o(irq), .ovf_o(ovf)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pwm = 1'b0;
    clr = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
  endtask

  task automatic wave(input int hi, input int lo, input int n);
    for (int k = 0; k < n; k++) begin
      pwm = 1'b1; idle(hi);
      pwm = 1'b0; idle(lo);
    end
  endtask

  task automatic pulse_clr();
    clr = 1'b1; idle(1);
    clr = 1'b0; idle(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 period", period, 0);
    chk("R1 width", width, 0);
    chk("R1 irq", irq, 0);
    chk("R1 ovf", ovf, 0);
  endtask

  task automatic t_rising();
    tb_psc = 0; pol = 0; cpsc = 0; filt = 0;
    do_reset();
    wave(30, 50, 4); idle(10);
    chk("R2 period 30/50", period, 80);
    chk("R3 width 30/50", width, 30);
    wave(7, 3, 5); idle(10);
    chk("R2 period 7/3", period, 10);
    chk("R3 width 7/3", width, 7);
  endtask

  task automatic t_falling();
    tb_psc = 0; pol = 1; cpsc = 0; filt = 0;
    do_reset();
    wave(30, 50, 4); idle(10);
    chk("R4 period", period, 80);
    chk("R4 width low", width, 50);
    pol = 0;
  endtask

  task automatic t_tbpsc();
    tb_psc = 3; pol = 0; cpsc = 0; filt = 0;
    do_reset();
    wave(40, 80, 4); idle(10);
    chk("R5 psc3 period", period, 30);
    chk("R5 psc3 width", width, 10);
    tb_psc = 5;
    do_reset();
    wave(12, 36, 4); idle(10);
    chk("R5 psc5 period", period, 8);
    chk("R5 psc5 width", width, 2);
    tb_psc = 0;
  endtask

  task automatic t_cpsc();
    tb_psc = 0; pol = 0; cpsc = 1; filt = 0;
    do_reset();
    pwm = 1'b1; idle(20);
    chk("R6 first trig no irq", irq, 0);
    pwm = 1'b0; idle(20);
    chk("R6 first opp no width", width, 0);
    pwm = 1'b1; idle(20);
    chk("R6 second trig irq", irq, 1);
    chk("R6 second trig period", period, 40);
    pwm = 1'b0; idle(20);
    chk("R6 second opp width", width, 20);
    cpsc = 0;
  endtask

  task automatic t_filter();
    tb_psc = 0; pol = 0; cpsc = 0; filt = 3;
    do_reset();
    wave(20, 20, 4); idle(10);
    chk("R7 filtered period", period, 40);
    chk("R7 filtered width", width, 20);
    pulse_clr();
    idle(30);
    pwm = 1'b1; idle(2);
    pwm = 1'b0; idle(30);
    chk("R7 glitch no irq", irq, 0);
    chk("R7 glitch period kept", period, 40);
    chk("R7 glitch width kept", width, 20);
    filt = 0;
  endtask

  task automatic t_irq();
    tb_psc = 0; pol = 0; cpsc = 0; filt = 0;
    do_reset();
    wave(10, 10, 3); idle(50);
    chk("R8 irq held", irq, 1);
    pulse_clr();
    chk("R8 irq cleared", irq, 0);
  endtask

  task automatic t_ovf();
    tb_psc = 0; pol = 0; cpsc = 0; filt = 0;
    do_reset();
    wave(10, 10, 2);
    chk("R9 ovf before wrap", ovf, 0);
    idle(66000);
    chk("R9 ovf set", ovf, 1);
    chk("R9 period zero", period, 0);
    pulse_clr();
    chk("R10 ovf cleared", ovf, 0);
    wave(10, 10, 1); idle(5);
    chk("R10 first trig after wrap", period, 0);
    wave(10, 10, 2); idle(5);
    chk("R10 period restored", period, 20);
  endtask

  initial begin
    t_reset();
    t_rising();
    t_falling();
    t_tbpsc();
    t_cpsc();
    t_filter();
    t_irq();
    t_ovf();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 190000; i++) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule